// File: doc/BRIEF.md
# Linear-Seed Newton Reciprocal and Divide Unit

This block computes the reciprocal of a positive fixed-point divisor. It can also scale a complex numerator by that reciprocal to form a quotient. The divisors it expects lie in a narrow, known band, namely [1.0, 2.0) in unsigned Q1.15. Because the band is narrow, the first guess of 1/x needs no table. A straight line with fixed slope and bias supplies it, at the cost of one constant multiply and one subtract. A single unrolled Newton step then squares the relative error of that guess. Everything is carried at 16 bits of precision.

Operations enter through a valid/ready handshake. Each one carries the divisor, a signed Q1.15 real and imaginary numerator, and a mode bit. The pipeline takes one operation per clock and has a fixed latency of three register stages: seed, refine, then scale. There is no output back-pressure, so results leave with a valid flag on a fixed schedule.

A two-state controller gates the input side:
- State `ST_BOOT` is entered on reset. In this state `in_ready` is low.
- On the first clock edge after reset is released, the transition `boot_to_live` moves the controller to `ST_LIVE`.
- In `ST_LIVE`, `in_ready` is high. The only transition out of `ST_LIVE` is `live_hold` back to itself, until the next reset.

Top module: `nr_recip_div`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are low. `in_ready` rises at the first clock edge after reset release and then stays high.
- R2: An operation accepted at clock edge n (`in_valid` and `in_ready` both high) produces `out_valid` high after edge n+2 for exactly one cycle. `out_valid` is low in every cycle that has no matching accept. Back-to-back accepts give back-to-back results.
- R3: The seed is y0 = 46261 − floor(15420·x / 2^15). Here x is the 16-bit divisor code, read as unsigned Q1.15.
- R4: The refined value is computed as follows:
  - e = floor(x·y0 / 2^15).
  - t = 65536 − e, or 0 if that is negative.
  - y1 = min(65535, floor(y0·t / 2^15)).
- R5: In reciprocal mode (`in_mode` = 0) with x ≥ 0x8000, `out_re` = y1 (unsigned Q1.15) and `out_im` = 0.
- R6: In divide mode (`in_mode` = 1) with x ≥ 0x8000, each output part is floor(n·y1 / 2^15), clamped to [−32768, 32767]. Here n is the matching signed Q1.15 numerator part.
- R7: For every divisor in [0x8000, 0xFFFF], the reciprocal-mode result is within 0.5 % of the true value 2^30 / x.
- R8: In reciprocal mode, a divisor below 0x8000 (including zero) gives `out_re` = 0xFFFF and `out_im` = 0.
- R9: In divide mode, a divisor below 0x8000 gives each part a fixed value set by the sign of its numerator part:
  - 0x7FFF if the part is positive.
  - 0x8000 if the part is negative.
  - 0x0000 if the part is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the input fields |
| in_ready | output | 1 | Unit accepts an operation this cycle |
| in_divisor | input | 16 | Unsigned Q1.15 divisor |
| in_num_re | input | 16 | Signed Q1.15 numerator, real part |
| in_num_im | input | 16 | Signed Q1.15 numerator, imaginary part |
| in_mode | input | 1 | 0 = reciprocal, 1 = complex divide |
| out_valid | output | 1 | Result present on the output fields |
| out_re | output | 16 | Reciprocal (unsigned) or real quotient (signed) |
| out_im | output | 16 | Zero or imaginary quotient (signed) |

## Verification
The assertions assume three things about the inputs:
- `in_valid` is low while reset is asserted.
- The input fields are stable at the edge that accepts them.
- The coarse result window checked for reciprocal mode holds only because in-band divisors never leave the fitted interval.

The stimulus drives inputs half a cycle away from the sampling edge and keeps `in_valid` low through reset. It draws about seven in eight divisors from the supported band, and the rest fall below it to reach the saturation paths. Numerators span the full signed range, including −32768 and zero, so the clamp and the sign-dependent saturation are both reached.

// File: rtl/nr_recip_pkg.sv
package nr_recip_pkg;

    // Input-side controller states
    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_LIVE = 1'b1
    } rdy_state_e;

    // Operation selector carried down the pipeline
    typedef enum logic {
        OP_RECIP = 1'b0,
        OP_DIV   = 1'b1
    } op_mode_e;

endpackage

// File: rtl/nr_seed_fit.sv
// Linear first guess of 1/x: one constant multiply and one subtract.
module nr_seed_fit #(
    parameter int W     = 16,
    parameter int FRAC  = 15,
    parameter int SLOPE = 15420,
    parameter int BIAS  = 46261,
    parameter int X_MIN = 32768
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y0,
    output logic         below
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0] SLOPE_C = W'(SLOPE);
    localparam logic [W-1:0] BIAS_C  = W'(BIAS);
    localparam logic [W-1:0] XMIN_C  = W'(X_MIN);

    logic [PW-1:0] prod;
    logic [PW-1:0] prod_sh;
    logic [W-1:0]  scaled;

    assign prod    = {{W{1'b0}}, SLOPE_C} * {{W{1'b0}}, x};
    assign prod_sh = prod >> FRAC;

    always_comb begin
        if (|prod_sh[PW-1:W]) begin
            scaled = '1;
        end else begin
            scaled = prod_sh[W-1:0];
        end
    end

    assign y0    = BIAS_C - scaled;
    assign below = (x < XMIN_C);
endmodule

// File: rtl/nr_refine_step.sv
// One unrolled Newton step: y1 = y0 * (2 - x*y0), all Q1.15.
module nr_refine_step #(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y0,
    output logic [W-1:0] y1
);
    localparam int XW = 2 * W;
    localparam int PW = 2 * W + 2;
    localparam logic [W+1:0] TWO_C = (W+2)'(1) << (FRAC + 1);

    logic [XW-1:0] xy;
    logic [XW-1:0] xy_sh;
    logic [W:0]    err;
    logic [W+1:0]  corr;
    logic [PW-1:0] prod;
    logic [PW-1:0] prod_sh;

    assign xy    = {{W{1'b0}}, x} * {{W{1'b0}}, y0};
    assign xy_sh = xy >> FRAC;

    always_comb begin
        if (|xy_sh[XW-1:W+1]) begin
            err = '1;
        end else begin
            err = xy_sh[W:0];
        end
    end

    always_comb begin
        if ({1'b0, err} > TWO_C) begin
            corr = '0;
        end else begin
            corr = TWO_C - {1'b0, err};
        end
    end

    assign prod    = {{(W+2){1'b0}}, y0} * {{W{1'b0}}, corr};
    assign prod_sh = prod >> FRAC;

    always_comb begin
        if (|prod_sh[PW-1:W]) begin
            y1 = '1;
        end else begin
            y1 = prod_sh[W-1:0];
        end
    end
endmodule

// File: rtl/nr_quot_scale.sv
// Output formatting: reciprocal pass-through or complex scale with clamping.
module nr_quot_scale #(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic         div_mode,
    input  logic         bad,
    input  logic [W-1:0] y1,
    input  logic [W-1:0] num_re,
    input  logic [W-1:0] num_im,
    output logic [W-1:0] q_re,
    output logic [W-1:0] q_im
);
    localparam int PW = 2 * W + 1;
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] num  [2];
    logic [W-1:0] part [2];

    assign num[0] = num_re;
    assign num[1] = num_im;

    for (genvar g = 0; g < 2; g++) begin : g_part
        logic signed [PW-1:0] prod;
        logic signed [PW-1:0] shifted;
        logic                 fits;
        logic [W-1:0]         clamp;
        logic [W-1:0]         sat;

        assign prod    = $signed({{(W+1){num[g][W-1]}}, num[g]})
                       * $signed({{(W+1){1'b0}}, y1});
        assign shifted = prod >>> FRAC;
        assign fits    = (shifted[PW-1:W-1] == '0) || (shifted[PW-1:W-1] == '1);

        always_comb begin
            if (fits) begin
                clamp = shifted[W-1:0];
            end else if (shifted[PW-1]) begin
                clamp = NEG_MAX;
            end else begin
                clamp = POS_MAX;
            end
        end

        always_comb begin
            if (num[g] == '0) begin
                sat = '0;
            end else if (num[g][W-1]) begin
                sat = NEG_MAX;
            end else begin
                sat = POS_MAX;
            end
        end

        assign part[g] = bad ? sat : clamp;
    end

    always_comb begin
        if (div_mode) begin
            q_re = part[0];
            q_im = part[1];
        end else begin
            q_re = bad ? '1 : y1;
            q_im = '0;
        end
    end
endmodule

// File: rtl/nr_recip_div.sv
module nr_recip_div
    import nr_recip_pkg::*;
#(
    parameter int W          = 16,
    parameter int FRAC       = 15,
    parameter int SEED_SLOPE = 15420,
    parameter int SEED_BIAS  = 46261,
    parameter int X_MIN      = 32768
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_divisor,
    input  logic [W-1:0] in_num_re,
    input  logic [W-1:0] in_num_im,
    input  logic         in_mode,
    output logic         out_valid,
    output logic [W-1:0] out_re,
    output logic [W-1:0] out_im
);
    // ---------------- input-side controller ----------------
    rdy_state_e st_q;
    rdy_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_BOOT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BOOT: st_d = ST_LIVE;   // boot_to_live
            ST_LIVE: st_d = ST_LIVE;   // live_hold
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        unique case (st_q)
            ST_BOOT: in_ready = 1'b0;
            ST_LIVE: in_ready = 1'b1;
        endcase
    end

    logic accept;
    assign accept = in_valid && in_ready;

    // ---------------- stage 1: seed ----------------
    logic [W-1:0] seed_y0;
    logic         seed_below;

    nr_seed_fit #(
        .W(W), .FRAC(FRAC), .SLOPE(SEED_SLOPE), .BIAS(SEED_BIAS), .X_MIN(X_MIN)
    ) u_seed (
        .x     (in_divisor),
        .y0    (seed_y0),
        .below (seed_below)
    );

    logic         s1_v;
    logic         s1_bad;
    op_mode_e     s1_mode;
    logic [W-1:0] s1_x;
    logic [W-1:0] s1_y0;
    logic [W-1:0] s1_re;
    logic [W-1:0] s1_im;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_bad  <= 1'b0;
            s1_mode <= OP_RECIP;
            s1_x    <= '0;
            s1_y0   <= '0;
            s1_re   <= '0;
            s1_im   <= '0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_bad  <= seed_below;
                s1_mode <= op_mode_e'(in_mode);
                s1_x    <= in_divisor;
                s1_y0   <= seed_y0;
                s1_re   <= in_num_re;
                s1_im   <= in_num_im;
            end
        end
    end

    // ---------------- stage 2: refine ----------------
    logic [W-1:0] ref_y1;

    nr_refine_step #(.W(W), .FRAC(FRAC)) u_refine (
        .x  (s1_x),
        .y0 (s1_y0),
        .y1 (ref_y1)
    );

    logic         s2_v;
    logic         s2_bad;
    op_mode_e     s2_mode;
    logic [W-1:0] s2_y1;
    logic [W-1:0] s2_re;
    logic [W-1:0] s2_im;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_bad  <= 1'b0;
            s2_mode <= OP_RECIP;
            s2_y1   <= '0;
            s2_re   <= '0;
            s2_im   <= '0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_bad  <= s1_bad;
                s2_mode <= s1_mode;
                s2_y1   <= ref_y1;
                s2_re   <= s1_re;
                s2_im   <= s1_im;
            end
        end
    end

    // ---------------- stage 3: scale / format ----------------
    logic [W-1:0] fmt_re;
    logic [W-1:0] fmt_im;

    nr_quot_scale #(.W(W), .FRAC(FRAC)) u_scale (
        .div_mode (s2_mode == OP_DIV),
        .bad      (s2_bad),
        .y1       (s2_y1),
        .num_re   (s2_re),
        .num_im   (s2_im),
        .q_re     (fmt_re),
        .q_im     (fmt_im)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s2_v;
            if (s2_v) begin
                out_re <= fmt_re;
                out_im <= fmt_im;
            end
        end
    end
endmodule

// File: rtl/nr_recip_div_chk.sv
module nr_recip_div_chk #(
    parameter int W     = 16,
    parameter int X_MIN = 32768
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_divisor,
    input logic [W-1:0] in_num_re,
    input logic         in_mode,
    input logic         out_valid,
    input logic [W-1:0] out_re,
    input logic [W-1:0] out_im
);
    localparam logic [W-1:0] XMIN_C = W'(X_MIN);
    localparam logic [W-1:0] WIN_LO = W'((1 << (W-2)) - (1 << (W-7)));
    localparam logic [W-1:0] WIN_HI = W'((1 << (W-1)) + (1 << (W-7)));

    logic acc;
    assign acc = in_valid && in_ready;

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_ready) |-> in_ready);                                               // R1

    AST_ISSUE_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc, 3) |-> out_valid);                                                // R2

    AST_RESULT_HAS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(acc, 3));                                                // R2

    AST_RECIP_IMAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && !in_mode, 3) |-> (out_im == '0));                               // R5

    AST_RECIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && !in_mode && (in_divisor >= XMIN_C), 3)
            |-> (out_re >= WIN_LO) && (out_re <= WIN_HI));                           // R7

    AST_RECIP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && !in_mode && (in_divisor < XMIN_C), 3) |-> (out_re == '1));      // R8

    AST_DIV_ZERO_PART: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && in_mode && (in_divisor < XMIN_C) && (in_num_re == '0), 3)
            |-> (out_re == '0));                                                     // R9
endmodule

bind nr_recip_div nr_recip_div_chk #(.W(W), .X_MIN(X_MIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_divisor (in_divisor),
    .in_num_re  (in_num_re),
    .in_mode    (in_mode),
    .out_valid  (out_valid),
    .out_re     (out_re),
    .out_im     (out_im)
);

// File: tb/nr_recip_div_tb.sv
module nr_recip_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_divisor = '0;
    logic [15:0] in_num_re = '0;
    logic [15:0] in_num_im = '0;
    logic        in_mode = 1'b0;
    logic        out_valid;
    logic [15:0] out_re;
    logic [15:0] out_im;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int q_due[$];
    int q_x[$];
    int q_mode[$];
    int q_re[$];
    int q_im[$];

    always #5 clk = ~clk;

    nr_recip_div u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_divisor (in_divisor),
        .in_num_re  (in_num_re),
        .in_num_im  (in_num_im),
        .in_mode    (in_mode),
        .out_valid  (out_valid),
        .out_re     (out_re),
        .out_im     (out_im)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Reference from the requirement formulas: seed per R3, refine per R4
    function automatic longint ref_y1(input longint x);
        longint y0, e, t, y1;
        y0 = (46261 - ((15420 * x) >> 15)) & 64'hFFFF;
        e  = (x * y0) >> 15;
        t  = 65536 - e;
        if (t < 0) t = 0;
        y1 = (y0 * t) >> 15;
        if (y1 > 65535) y1 = 65535;
        return y1;
    endfunction

    function automatic longint ref_part(input longint x, input longint n);
        longint q;
        if (x < 32768) begin                       // R9
            if (n > 0) return 32767;
            if (n < 0) return -32768;
            return 0;
        end
        q = (n * ref_y1(x)) >>> 15;                // R6
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    function automatic longint sx16(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check_outputs();
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            int x, m, nre, nim;
            x = q_x.pop_front(); m = q_mode.pop_front();
            nre = q_re.pop_front(); nim = q_im.pop_front();
            void'(q_due.pop_front());
            check(out_valid === 1'b1, "R2", "out_valid on due cycle", longint'(out_valid), 1);
            if (m == 0) begin
                if (x < 32768) begin
                    check(out_re == 16'hFFFF, "R8", "recip sat re", out_re, 65535);
                    check(out_im == 16'h0000, "R8", "recip sat im", out_im, 0);
                end else begin
                    longint e1;
                    real exact, rel;
                    e1 = ref_y1(x);
                    check(longint'(out_re) == e1, "R3,R4,R5", "recip value", out_re, e1);
                    check(out_im == 16'h0000, "R5", "recip im zero", out_im, 0);
                    exact = 1073741824.0 / real'(x);
                    rel = (real'(out_re) - exact) / exact;
                    if (rel < 0.0) rel = -rel;
                    check(rel <= 0.005, "R7", "recip accuracy x1e6", longint'(rel * 1.0e6), 5000);
                end
            end else begin
                longint er, ei;
                string tag;
                tag = (x < 32768) ? "R9" : "R6";
                er = ref_part(x, nre);
                ei = ref_part(x, nim);
                check(sx16(out_re) == er, tag, "divide re", sx16(out_re), er);
                check(sx16(out_im) == ei, tag, "divide im", sx16(out_im), ei);
            end
        end else begin
            check(out_valid === 1'b0, "R2", "out_valid idle", longint'(out_valid), 0);
        end
    endtask

    task automatic step(input bit v, input int x, input bit m, input int nre, input int nim);
        @(negedge clk);
        cyc++;
        check_outputs();
        in_valid   = v;
        in_divisor = 16'(x);
        in_mode    = m;
        in_num_re  = 16'(nre);
        in_num_im  = 16'(nim);
        if (v && in_ready) begin
            q_due.push_back(cyc + 3);
            q_x.push_back(x & 16'hFFFF);
            q_mode.push_back(int'(m));
            q_re.push_back(nre);
            q_im.push_back(nim);
        end
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(in_ready === 1'b0, "R1", "in_ready in reset", longint'(in_ready), 0);
        check(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        check(in_ready === 1'b0, "R1", "in_ready before first edge", longint'(in_ready), 0);
        idle();
        check(in_ready === 1'b1, "R1", "in_ready after boot", longint'(in_ready), 1);

        // Directed corners: band edges (R5, R7) and saturation (R8)
        step(1'b1, 32768, 1'b0, 0, 0);
        step(1'b1, 65535, 1'b0, 0, 0);
        step(1'b1, 0,     1'b0, 0, 0);
        step(1'b1, 32767, 1'b0, 0, 0);
        step(1'b1, 49152, 1'b0, 0, 0);
        // Divide mode: extreme numerators (R6) and below-band signs (R9)
        step(1'b1, 32768, 1'b1, -32768, 32767);
        step(1'b1, 40000, 1'b1, -1, 1);
        step(1'b1, 100,   1'b1, 12345, -5);
        step(1'b1, 0,     1'b1, 0, -32768);
        repeat (5) idle();
        // Sparse issue pattern (R2)
        step(1'b1, 50000, 1'b0, 0, 0);
        idle();
        step(1'b1, 60000, 1'b1, 20000, -20000);
        repeat (2) idle();
        check(in_ready === 1'b1, "R1", "in_ready holds", longint'(in_ready), 1);

        // Constrained random
        for (int i = 0; i < 2000; i++) begin
            bit v, m;
            int x;
            v = ($urandom % 4) != 0;
            m = $urandom % 2;
            if (($urandom % 8) == 0) x = $urandom % 32768;
            else                     x = 32768 + ($urandom % 32768);
            step(v, x, m, int'(sx16(16'($urandom))), int'(sx16(16'($urandom))));
        end
        repeat (6) idle();
        check(q_due.size() == 0, "R2", "all results returned", q_due.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule